// File: doc/BRIEF.md
# PCI interrupt steering router

This block takes the four interrupt pins of each add-in card slot and delivers them to a sixteen-entry legacy IRQ request vector. The pins are active-low and level-sensitive. Each slot's pins are first rotated onto four shared board lines. The rotation depends on the slot's position, so cards that use only their first pin do not all land on the same board line. Pins that meet on a board line are wire-ORed.

Each board line then passes through its own 8-bit routing register. The register either leaves the line disconnected or steers it to one of sixteen IRQ outputs. When several lines are steered to the same IRQ, that output is the OR of their requests. Software programs and reads back the routing registers through a simple configuration write port with a combinational read path. The IRQ outputs are active-high levels that follow the pins in the same cycle.

Top module: `irq_steer_router`

## Requirements
- R1: While `rst` is high on a clock edge, all four routing registers are cleared. After reset they read 0x00 and `irq_req` stays all-zero whatever the slot pins do.
- R2: A write with `cfg_we` high to address 0xC0, 0xC1, 0xC2 or 0xC3 stores all 8 bits of `cfg_wdata` in the routing register of board line 0, 1, 2 or 3. The value reads back on `cfg_rdata` at the same address from the next cycle on.
- R3: A write to any address other than 0xC0 to 0xC3 changes no routing register. A read of such an address returns 0x00.
- R4: A board line whose routing register has bit 7 clear drives no bit of `irq_req`.
- R5: A board line whose routing register has bit 7 set drives bit N of `irq_req`, where N is register bits [3:0]. Register bits [6:4] have no effect on routing.
- R6: Pin p of slot k appears on `slot_int_n[4*k+p]`, where p=0 is INTA and p=3 is INTD. It drives board line (p+k) mod 4. So slot 0 maps A,B,C,D to lines 0,1,2,3, slot 1 to 1,2,3,0, slot 2 to 2,3,0,1 and slot 3 to 3,0,1,2.
- R7: A slot pin is asserted when low. A routed request appears on `irq_req` as a high level in the same cycle as the pin change and drops in the same cycle the pin is released.
- R8: A board line is active when any pin mapped to it is low. An IRQ output is high when any enabled board line routed to it is active.
- R9: A routing write first affects `irq_req` after the clock edge that captures it. Before that edge the old routing still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Read data for `cfg_addr` (combinational) |
| slot_int_n | input | 16 | Slot interrupt pins, active-low, slot k pin p at bit 4*k+p |
| irq_req | output | 16 | IRQ request levels, active-high |

## Verification
The bench sweeps every board line through all sixteen IRQ numbers, both enabled and disabled, and presses every slot pin by itself for each setting. A wrong rotation therefore shows up as the request on a neighbouring IRQ or as a missing request. Spare bits [6:4] are set during the sweep, so a decoder that reads too wide a field sends requests to an IRQ above 15 or to the wrong IRQ. Pseudo-random configurations that put several lines on one IRQ, with many pins pressed at once, catch an overwrite where an OR belongs. Writes to neighbouring addresses, and a sample taken just before the capturing edge, catch a loose address decode and routing that changes too early.

// File: rtl/irq_rtr_pkg.sv
package irq_rtr_pkg;

    localparam int LINES      = 4;
    localparam int IRQ_W      = 4;
    localparam int NUM_IRQ    = 1 << IRQ_W;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 8;
    localparam logic [ADDR_W-1:0] ROUTE_BASE = 8'hC0;

    typedef struct packed {
        logic             en;
        logic [2:0]       spare;
        logic [IRQ_W-1:0] irq;
    } route_t;

    typedef route_t route_arr_t [LINES];

    // Board line reached by pin p of slot k: rotate by slot position.
    function automatic int line_of(input int slot, input int pin);
        return (pin + slot) % LINES;
    endfunction

    function automatic logic [ADDR_W-1:0] route_addr(input int line);
        return ROUTE_BASE + ADDR_W'(line);
    endfunction

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_rtr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output route_arr_t        routes
);

    route_t route_q [LINES];
    logic   hit     [LINES];

    for (genvar l = 0; l < LINES; l++) begin : g_reg
        assign hit[l] = cfg_we && (cfg_addr == route_addr(l));

        always_ff @(posedge clk) begin
            if (rst)
                route_q[l] <= '0;
            else if (hit[l])
                route_q[l] <= route_t'(cfg_wdata);
        end

        assign routes[l] = route_q[l];

        // R2: a write lands in the addressed register
        a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
            ($past(hit[l]) && !$past(rst)) |-> (route_q[l] == route_t'($past(cfg_wdata))));

        // R3: without a hit the register holds
        a_r3_hold: assert property (@(posedge clk) disable iff (rst)
            (!$past(hit[l]) && !$past(rst)) |-> $stable(route_q[l]));

        // R1: registers come out of reset cleared
        a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (route_q[l] == '0));
    end

    always_comb begin
        cfg_rdata = '0;
        for (int l = 0; l < LINES; l++)
            if (cfg_addr == route_addr(l))
                cfg_rdata = route_q[l];
    end

endmodule

// File: rtl/irq_slot_swizzle.sv
module irq_slot_swizzle
    import irq_rtr_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    localparam int PIN_W    = NUM_SLOTS * LINES
)(
    input  logic [PIN_W-1:0] slot_int_n,
    output logic [LINES-1:0] line_act
);

    always_comb begin
        line_act = '0;
        for (int s = 0; s < NUM_SLOTS; s++)
            for (int p = 0; p < LINES; p++)
                if (!slot_int_n[s*LINES + p])
                    line_act[2'(line_of(s, p))] = 1'b1;
    end

endmodule

// File: rtl/irq_line_steer.sv
module irq_line_steer
    import irq_rtr_pkg::*;
(
    input  route_arr_t         routes,
    input  logic [LINES-1:0]   line_act,
    output logic [NUM_IRQ-1:0] irq_req
);

    always_comb begin
        irq_req = '0;
        for (int l = 0; l < LINES; l++)
            if (routes[l].en && line_act[l])
                irq_req[routes[l].irq] = 1'b1;
    end

endmodule

// File: rtl/irq_steer_router.sv
module irq_steer_router
    import irq_rtr_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    localparam int PIN_W    = NUM_SLOTS * LINES
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [DATA_W-1:0]  cfg_wdata,
    output logic [DATA_W-1:0]  cfg_rdata,
    input  logic [PIN_W-1:0]   slot_int_n,
    output logic [NUM_IRQ-1:0] irq_req
);

    route_arr_t       routes;
    logic [LINES-1:0] line_act;

    irq_route_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .routes    (routes)
    );

    irq_slot_swizzle #(.NUM_SLOTS(NUM_SLOTS)) u_swz (
        .slot_int_n (slot_int_n),
        .line_act   (line_act)
    );

    irq_line_steer u_steer (
        .routes   (routes),
        .line_act (line_act),
        .irq_req  (irq_req)
    );

    logic [LINES-1:0] en_mask;
    logic [LINES-1:0] live_mask;
    always_comb begin
        for (int l = 0; l < LINES; l++) begin
            en_mask[l]   = routes[l].en;
            live_mask[l] = routes[l].en && line_act[l];
        end
    end

    // R4: with every line disabled no IRQ is requested
    a_r4_disabled_silent: assert property (@(posedge clk) disable iff (rst)
        (en_mask == '0) |-> (irq_req == '0));

    // R8: no more IRQs than live enabled lines
    a_r8_or_bound: assert property (@(posedge clk) disable iff (rst)
        $countones(irq_req) <= $countones(live_mask));

    // R7: all pins released means no request
    a_r7_idle_pins: assert property (@(posedge clk) disable iff (rst)
        (&slot_int_n) |-> (irq_req == '0));

    // R1: first cycle after reset requests nothing
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq_req == '0));

endmodule

// File: tb/irq_steer_router_bench.sv
module irq_steer_router_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [7:0]  cfg_addr;
    logic [7:0]  cfg_wdata;
    logic [7:0]  cfg_rdata;
    logic [15:0] slot_int_n;
    logic [15:0] irq_req;

    int checks = 0;
    int errors = 0;
    logic [7:0]  mdl [4];
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #2 clk = ~clk;

    irq_steer_router u_irq_steer_router (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .slot_int_n(slot_int_n), .irq_req(irq_req)
    );

    function automatic logic [15:0] expect_irq(input logic [15:0] pins);
        logic [15:0] r = '0;
        for (int s = 0; s < 4; s++)
            for (int p = 0; p < 4; p++)
                if (!pins[4*s+p]) begin
                    int ln = (p + s) % 4;
                    if (mdl[ln][7]) r[mdl[ln][3:0]] = 1'b1;
                end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a >= 8'hC0 && a <= 8'hC3) mdl[a - 8'hC0] = d;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
        cfg_addr = a;
        #1;
        chk(tag, {8'h00, cfg_rdata}, {8'h00, exp});
    endtask

    function automatic logic [31:0] step(input logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = 8'h00; cfg_wdata = 8'h00;
        slot_int_n = 16'h0000;
        for (int l = 0; l < 4; l++) mdl[l] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk("R1 irq after reset with all pins low", irq_req, 16'h0000);
        for (int l = 0; l < 4; l++) rd_chk("R1 register cleared", 8'(8'hC0 + l), 8'h00);

        // R2 readback of all 8 bits
        wr(8'hC0, 8'h8A); wr(8'hC1, 8'h35); wr(8'hC2, 8'hF1); wr(8'hC3, 8'h7E);
        rd_chk("R2 readback C0", 8'hC0, 8'h8A);
        rd_chk("R2 readback C1", 8'hC1, 8'h35);
        rd_chk("R2 readback C2", 8'hC2, 8'hF1);
        rd_chk("R2 readback C3", 8'hC3, 8'h7E);

        // R3 neighbouring addresses ignored, read as zero
        wr(8'hBF, 8'hFF); wr(8'hC4, 8'h99); wr(8'h40, 8'h81); wr(8'h00, 8'h80);
        rd_chk("R3 read BF", 8'hBF, 8'h00);
        rd_chk("R3 read C4", 8'hC4, 8'h00);
        rd_chk("R3 C0 untouched", 8'hC0, 8'h8A);
        rd_chk("R3 C3 untouched", 8'hC3, 8'h7E);
        slot_int_n = 16'h0000; #1;
        chk("R3 routing unchanged", irq_req, expect_irq(16'h0000));

        // R4/R5/R6 sweep: one line, every IRQ, enabled and disabled, every pin
        for (int l = 0; l < 4; l++) wr(8'(8'hC0 + l), 8'h00);
        for (int l = 0; l < 4; l++) begin
            for (int q = 0; q < 16; q++) begin
                for (int en = 0; en < 2; en++) begin
                    logic [7:0] v;
                    v = {en[0], 3'(q * 3 + l), 4'(q)};
                    wr(8'(8'hC0 + l), v);
                    for (int pin = 0; pin < 16; pin++) begin
                        logic [15:0] pv;
                        pv = ~(16'h1 << pin);
                        slot_int_n = pv; #1;
                        if (en == 0) chk("R4 disabled line silent", irq_req, 16'h0000);
                        else chk("R5 R6 swizzle and steer", irq_req, expect_irq(pv));
                    end
                    slot_int_n = 16'hFFFF;
                end
                wr(8'(8'hC0 + l), 8'h00);
            end
        end

        // R7 level follows pin in the same cycle
        wr(8'hC2, 8'h89);
        slot_int_n = ~16'h0004; #1;
        chk("R7 request rises with pin", irq_req, 16'h0200);
        slot_int_n = 16'hFFFF; #1;
        chk("R7 request drops with pin", irq_req, 16'h0000);

        // R8 many lines and pins combined
        for (int it = 0; it < 400; it++) begin
            lfsr = step(lfsr);
            if (it % 4 == 0) wr(8'(8'hC0 + lfsr[9:8]), lfsr[7:0] | {it[4], 7'h0});
            lfsr = step(lfsr);
            slot_int_n = lfsr[15:0] | lfsr[31:16]; #1;
            chk("R8 OR of lines and pins", irq_req, expect_irq(slot_int_n));
        end
        wr(8'hC0, 8'h85); wr(8'hC1, 8'h85); wr(8'hC2, 8'h85); wr(8'hC3, 8'h00);
        slot_int_n = ~16'h0003; #1;
        chk("R8 two lines share IRQ5", irq_req, 16'h0020);

        // R9 write takes effect only after its edge
        slot_int_n = ~16'h0001;
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 8'hC0; cfg_wdata = 8'h8C;
        #1;
        chk("R9 old routing before edge", irq_req, 16'h0020);
        @(negedge clk);
        cfg_we = 1'b0; mdl[0] = 8'h8C; #1;
        chk("R9 new routing after edge", irq_req, 16'h1000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule